// File: doc/BRIEF.md
# Push-Button Power Sequencer

This block is the supervisory sequencer of an always-on board controller. A single low-active front-panel button turns the board on and off. The raw button level is synchronised and debounced. A press followed by a release raises the power-on enable. The sequencer then waits for the module power-good input and lets a settling delay run. After that it pulses an open-drain reset line for the external Ethernet PHYs, low for a fixed time and released again. It then enters the operating group, where it tracks warning and soft-error inputs.

Holding the button for the long-press time inside the operating group starts power-off. A slot-shutdown wait follows, then the enable drops and the block waits for the button to be let go. A hard-error input overrides every state and cuts power. A press acknowledges the hard error, and the block then returns to idle through the release wait. A passthrough bus is gated so that it is only driven while power is on. An RGB status output shows the current phase. Every time interval is a parameter in clock cycles.

Top module: `pwrseq_top`

## Requirements
- R1: During and right after reset, pwr_en, phy_rst_oe, led_rgb and every pt_oe bit are 0.
- R2: A change of the raw button level takes effect only after the synchronised level has differed from the filtered level for DB_CYC consecutive cycles. A low glitch shorter than DB_CYC cycles while idle leaves pwr_en at 0.
- R3: From idle, pwr_en stays 0 while the button is held pressed. pwr_en goes to 1 once the debounced button is released, and led_rgb then shows the sequencing colour 3'b001.
- R4: While power-good is 0, phy_rst_oe stays 0. mod_pg is sampled synchronously. If it is driven high between two clock edges, phy_rst_oe first reads 1 PGD_CYC+1 cycles later and stays 1 for exactly RST_CYC cycles. The block is then in the ready substate.
- R5: In the operating group the substate is chosen each cycle with soft error above warning above ready, and it follows the inputs one cycle later. led_rgb is {red,green,blue}: ready 3'b010, warning 3'b110, soft or hard error 3'b100, idle or release wait 3'b000.
- R6: Holding the button from an operating substate for HOLD_CYC cycles after the debounced press enters slot shutdown. Slot shutdown shows 3'b001 and keeps pwr_en at 1 for exactly SLOT_CYC cycles. pwr_en then drops to 0, and led_rgb is 3'b000 until the button is released.
- R7: A press released before HOLD_CYC elapses keeps pwr_en at 1. During the hold, led_rgb keeps showing the substate that was active when the press began. After release the block returns to the operating group.
- R8: hard_err_in at 1 forces the hard-error state one cycle later from any state. pwr_en and pt_oe are then 0 and led_rgb is 3'b100, and this holds after hard_err_in falls.
- R9: A debounced press in hard error moves through acknowledge to the release wait, where led_rgb and pwr_en are 0. After release, a new press and release powers the board up again.
- R10: While pwr_en is 1, pt_out equals pt_in and every pt_oe bit is 1. While pwr_en is 0, pt_out and pt_oe are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_raw_n | input | 1 | Raw power button level, low while pressed |
| mod_pg | input | 1 | Module power-good, synchronous to clk |
| warn_in | input | 1 | Warning condition |
| soft_err_in | input | 1 | Soft-error condition |
| hard_err_in | input | 1 | Hard-error condition |
| pt_in | input | PT_W | Passthrough signals to the board side |
| pwr_en | output | 1 | Power-on enable for the board rails |
| phy_rst_oe | output | 1 | Open-drain PHY reset: 1 drives the line low, 0 releases it |
| led_rgb | output | 3 | Status LED {red,green,blue} |
| pt_out | output | PT_W | Gated passthrough data |
| pt_oe | output | PT_W | Per-bit output enable of the passthrough pads |

## Verification
The bench builds the block with DB_CYC=4, PGD_CYC=20, RST_CYC=10, HOLD_CYC=100 and SLOT_CYC=15 in place of the millisecond and second defaults. At these lengths the bench can count the exact settling delay, reset pulse width, long-press and slot-shutdown times cycle by cycle. It can also run glitches of every length below the debounce window, and power-cycle the board several times in one short run. The random phase flips the warning, soft-error and passthrough inputs every cycle, so every substate transition and the one-cycle response are covered.

// File: rtl/pwrseq_pkg.sv
// Shared state encoding and LED colour codes of the push-button power sequencer.
package pwrseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,     // waiting for a press
        ST_ARM,      // pressed, waiting for release before power-up
        ST_PGWAIT,   // enable on, waiting for module power-good
        ST_PGDLY,    // settling delay after power-good
        ST_PHYRST,   // PHY reset line driven low
        ST_READY,    // operating, no condition
        ST_WARN,     // operating, warning
        ST_SOFT,     // operating, soft error
        ST_HOLD,     // button held, timing the long press
        ST_SLOTDN,   // slot shutdown wait
        ST_OFFREL,   // power off, waiting for release
        ST_HARD,     // hard error latched
        ST_ACK       // hard error acknowledged
    } seq_state_t;

    localparam logic [2:0] LED_OFF = 3'b000;
    localparam logic [2:0] LED_SEQ = 3'b001;
    localparam logic [2:0] LED_GRN = 3'b010;
    localparam logic [2:0] LED_YEL = 3'b110;
    localparam logic [2:0] LED_RED = 3'b100;

    // True for the three substates of the operating group.
    function automatic logic is_oper(seq_state_t s);
        return (s == ST_READY) || (s == ST_WARN) || (s == ST_SOFT);
    endfunction

endpackage

// File: rtl/pwrseq_debounce.sv
// Button filter: two-flop synchroniser followed by a stability counter.
// The filtered level takes a new value only after the synchronised level has
// differed from it for STABLE_CYC consecutive cycles. Resets to released (1).
// Also flags a one-cycle pulse on each filtered falling edge (press).
module pwrseq_debounce #(
    parameter int unsigned STABLE_CYC = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_n,
    output logic level,
    output logic fall
);
    localparam int unsigned CW = (STABLE_CYC > 1) ? $clog2(STABLE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYC - 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          filt_q;
    logic          prev_q;

    // Bring the asynchronous button into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], raw_n};
    end

    // Count cycles of disagreement and accept the level once the count is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            filt_q <= 1'b1;
        end else if (sync_q[1] == filt_q) begin
            cnt_q  <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            filt_q <= sync_q[1];
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Remember the previous filtered level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= filt_q;
    end

    assign level = filt_q;
    assign fall  = prev_q & ~filt_q;

    // R2
    level_needs_full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_q) |-> ($past(cnt_q) == LAST));

endmodule

// File: rtl/pwrseq_timer.sv
// Reloadable down-counter shared by all timed states. A load sets the count;
// it then decrements to zero and rests there. Expired reads 1 at zero.
// A state that loads N-1 on entry and leaves on expiry lasts N cycles.
module pwrseq_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    // Load on request, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R6
    rests_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && expired) |=> expired);

endmodule

// File: rtl/pwrseq_fsm.sv
// Sequencer state machine. Assumes a debounced button level with a press
// pulse, and mod_pg synchronous to clk. It drives the timer load and decodes
// the Moore outputs: power enable, PHY reset drive and status LED colour.
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter int unsigned TW       = 8,
    parameter int unsigned PGD_CYC  = 20,
    parameter int unsigned RST_CYC  = 10,
    parameter int unsigned HOLD_CYC = 100,
    parameter int unsigned SLOT_CYC = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          btn_level,
    input  logic          btn_press,
    input  logic          mod_pg,
    input  logic          warn_in,
    input  logic          soft_err_in,
    input  logic          hard_err_in,
    input  logic          tmr_expired,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          pwr_en,
    output logic          phy_rst_oe,
    output logic [2:0]    led_rgb
);
    localparam logic [TW-1:0] PGD_LD  = TW'(PGD_CYC - 1);
    localparam logic [TW-1:0] RST_LD  = TW'(RST_CYC - 1);
    localparam logic [TW-1:0] HOLD_LD = TW'(HOLD_CYC - 1);
    localparam logic [TW-1:0] SLOT_LD = TW'(SLOT_CYC - 1);

    seq_state_t st_q, nxt, saved_q, oper_pick;

    // Operating substate wanted by the condition inputs, highest severity first.
    always_comb begin
        if (soft_err_in)  oper_pick = ST_SOFT;
        else if (warn_in) oper_pick = ST_WARN;
        else              oper_pick = ST_READY;
    end

    // Next state and timer load, with the hard-error override applied last.
    always_comb begin
        nxt      = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (st_q)
            ST_IDLE:   if (btn_press) nxt = ST_ARM;
            ST_ARM:    if (btn_level) nxt = ST_PGWAIT;
            ST_PGWAIT: if (mod_pg) begin
                           nxt = ST_PGDLY; tmr_load = 1'b1; tmr_val = PGD_LD;
                       end
            ST_PGDLY:  if (tmr_expired) begin
                           nxt = ST_PHYRST; tmr_load = 1'b1; tmr_val = RST_LD;
                       end
            ST_PHYRST: if (tmr_expired) nxt = ST_READY;
            ST_READY, ST_WARN, ST_SOFT: begin
                if (btn_press) begin
                    nxt = ST_HOLD; tmr_load = 1'b1; tmr_val = HOLD_LD;
                end else begin
                    nxt = oper_pick;
                end
            end
            ST_HOLD: begin
                if (btn_level) nxt = saved_q;
                else if (tmr_expired) begin
                    nxt = ST_SLOTDN; tmr_load = 1'b1; tmr_val = SLOT_LD;
                end
            end
            ST_SLOTDN: if (tmr_expired) nxt = ST_OFFREL;
            ST_OFFREL: if (btn_level) nxt = ST_IDLE;
            ST_HARD:   if (btn_press) nxt = ST_ACK;
            ST_ACK:    nxt = ST_OFFREL;
            default:   nxt = ST_IDLE;
        endcase
        if (hard_err_in && !(st_q == ST_HARD && btn_press)) begin
            nxt      = ST_HARD;
            tmr_load = 1'b0;
            tmr_val  = '0;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= nxt;
    end

    // Remember which operating substate a long-press timing started from.
    always_ff @(posedge clk) begin
        if (!rst_n)                                saved_q <= ST_READY;
        else if (is_oper(st_q) && nxt == ST_HOLD)  saved_q <= st_q;
    end

    // Moore output decode.
    always_comb begin
        pwr_en     = 1'b0;
        phy_rst_oe = 1'b0;
        led_rgb    = LED_OFF;
        case (st_q)
            ST_PGWAIT, ST_PGDLY: begin pwr_en = 1'b1; led_rgb = LED_SEQ; end
            ST_PHYRST: begin pwr_en = 1'b1; phy_rst_oe = 1'b1; led_rgb = LED_SEQ; end
            ST_READY:  begin pwr_en = 1'b1; led_rgb = LED_GRN; end
            ST_WARN:   begin pwr_en = 1'b1; led_rgb = LED_YEL; end
            ST_SOFT:   begin pwr_en = 1'b1; led_rgb = LED_RED; end
            ST_HOLD: begin
                pwr_en = 1'b1;
                case (saved_q)
                    ST_WARN: led_rgb = LED_YEL;
                    ST_SOFT: led_rgb = LED_RED;
                    default: led_rgb = LED_GRN;
                endcase
            end
            ST_SLOTDN: begin pwr_en = 1'b1; led_rgb = LED_SEQ; end
            ST_HARD, ST_ACK: led_rgb = LED_RED;
            default: ;
        endcase
    end

    // R3
    enable_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en) |-> ($past(st_q) == ST_ARM) && $past(btn_level));

    // R4
    phy_pulse_after_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_rst_oe) |-> ($past(st_q) == ST_PGDLY) && $past(tmr_expired));

    // R6
    slot_wait_timed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OFFREL && $past(st_q) == ST_SLOTDN) |-> $past(tmr_expired));

    // R8
    hard_error_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hard_err_in |=> (st_q == ST_HARD || st_q == ST_ACK));

endmodule

// File: rtl/pwrseq_top.sv
// Push-button power sequencer top. Wires the button filter, the shared timer
// and the state machine, and gates the passthrough pads so they are only
// driven while the power-on enable is high. Interval parameters are in cycles.
module pwrseq_top #(
    parameter int unsigned DB_CYC   = 1250000,    // 10 ms at 125 MHz
    parameter int unsigned PGD_CYC  = 625000,     // 5 ms settling delay
    parameter int unsigned RST_CYC  = 125000,     // 1 ms PHY reset pulse
    parameter int unsigned HOLD_CYC = 250000000,  // 2 s long press
    parameter int unsigned SLOT_CYC = 1250000,    // 10 ms slot shutdown
    parameter int unsigned PT_W     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            btn_raw_n,
    input  logic            mod_pg,
    input  logic            warn_in,
    input  logic            soft_err_in,
    input  logic            hard_err_in,
    input  logic [PT_W-1:0] pt_in,
    output logic            pwr_en,
    output logic            phy_rst_oe,
    output logic [2:0]      led_rgb,
    output logic [PT_W-1:0] pt_out,
    output logic [PT_W-1:0] pt_oe
);
    localparam int unsigned MAX_AB = (PGD_CYC > RST_CYC) ? PGD_CYC : RST_CYC;
    localparam int unsigned MAX_CD = (HOLD_CYC > SLOT_CYC) ? HOLD_CYC : SLOT_CYC;
    localparam int unsigned MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int unsigned TW     = $clog2(MAXC) + 1;

    logic          btn_level, btn_press;
    logic          tmr_load, tmr_expired;
    logic [TW-1:0] tmr_val;

    pwrseq_debounce #(.STABLE_CYC(DB_CYC)) u_btn (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_n (btn_raw_n),
        .level (btn_level),
        .fall  (btn_press)
    );

    pwrseq_timer #(.W(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    pwrseq_fsm #(
        .TW       (TW),
        .PGD_CYC  (PGD_CYC),
        .RST_CYC  (RST_CYC),
        .HOLD_CYC (HOLD_CYC),
        .SLOT_CYC (SLOT_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .btn_level   (btn_level),
        .btn_press   (btn_press),
        .mod_pg      (mod_pg),
        .warn_in     (warn_in),
        .soft_err_in (soft_err_in),
        .hard_err_in (hard_err_in),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .pwr_en      (pwr_en),
        .phy_rst_oe  (phy_rst_oe),
        .led_rgb     (led_rgb)
    );

    // One gated pad per passthrough bit: driven only while the board is on.
    for (genvar i = 0; i < PT_W; i++) begin : g_pad
        assign pt_out[i] = pwr_en & pt_in[i];
        assign pt_oe[i]  = pwr_en;
    end

    // R10
    pads_quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> (pt_oe == '0) && (pt_out == '0));

endmodule

// File: tb/sim_pwrseq_top.sv
// Bench for pwrseq_top with shortened intervals. Inputs change on the falling
// edge, outputs are sampled on the falling edge.
module sim_pwrseq_top;
    localparam int DB = 4, PGD = 20, RST = 10, HOLD = 100, SLOT = 15, PW = 4;

    logic clk = 1'b0;
    logic rst_n, btn_n, pg, warn, serr, herr;
    logic [PW-1:0] pt_in, pt_out, pt_oe;
    logic pwr_en, phy_oe;
    logic [2:0] led;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    pwrseq_top #(.DB_CYC(DB), .PGD_CYC(PGD), .RST_CYC(RST), .HOLD_CYC(HOLD),
                 .SLOT_CYC(SLOT), .PT_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .btn_raw_n(btn_n), .mod_pg(pg),
        .warn_in(warn), .soft_err_in(serr), .hard_err_in(herr), .pt_in(pt_in),
        .pwr_en(pwr_en), .phy_rst_oe(phy_oe), .led_rgb(led),
        .pt_out(pt_out), .pt_oe(pt_oe));

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [2:0] exp_oper(input logic w, input logic s);
        if (s) return 3'b100;
        if (w) return 3'b110;
        return 3'b010;
    endfunction

    // Press, release, power-good and PHY reset pulse; ends in ready.
    task automatic power_up();
        int n, m;
        pg = 1'b0;
        btn_n = 1'b0; step(DB + 8);
        chk(pwr_en == 1'b0, "R3", "pwr_en while held", pwr_en, 0);
        btn_n = 1'b1; step(DB + 8);
        chk(pwr_en == 1'b1, "R3", "pwr_en after release", pwr_en, 1);
        chk(led == 3'b001, "R3", "sequencing colour", led, 1);
        step(10);
        chk(phy_oe == 1'b0, "R4", "no reset without pg", phy_oe, 0);
        pg = 1'b1;
        n = 0;
        while (!phy_oe && n < 1000) begin step(1); n++; end
        chk(n == PGD + 1, "R4", "cycles pg to reset", n, PGD + 1);
        m = 0;
        while (phy_oe && m < 1000) begin step(1); m++; end
        chk(m == RST, "R4", "reset pulse width", m, RST);
        chk(led == 3'b010 && pwr_en, "R4", "ready after pulse", led, 2);
    endtask

    initial begin
        step(150000);
        errors++;
        $display("FAIL watchdog run did not finish actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n, m;
        logic [2:0] hold_col;
        void'($urandom(32'd2024));
        rst_n = 1'b0; btn_n = 1'b1; pg = 1'b0; warn = 1'b0; serr = 1'b0;
        herr = 1'b0; pt_in = '1;
        step(5);
        chk(!pwr_en && !phy_oe && led == 3'b000 && pt_oe == '0, "R1",
            "outputs in reset", {pwr_en, phy_oe, led}, 0);
        rst_n = 1'b1; step(3);
        chk(!pwr_en && !phy_oe && led == 3'b000 && pt_oe == '0, "R1",
            "outputs after reset", {pwr_en, phy_oe, led}, 0);
        chk(pt_out == '0, "R10", "pt_out while off", pt_out, 0);

        // R2: glitches shorter than the debounce window are ignored.
        for (int i = 0; i < 12; i++) begin
            n = 1 + ($urandom % (DB - 1));
            btn_n = 1'b0; step(n);
            btn_n = 1'b1; step(DB + 8);
            chk(pwr_en == 1'b0 && led == 3'b000, "R2", "glitch ignored", pwr_en, 0);
        end

        power_up();

        // R5 and R10: random conditions and passthrough data.
        for (int i = 0; i < 300; i++) begin
            warn  = ($urandom % 3) == 0;
            serr  = ($urandom % 5) == 0;
            pt_in = PW'($urandom);
            step(1);
            chk(led == exp_oper(warn, serr), "R5", "substate colour", led,
                exp_oper(warn, serr));
            chk(pt_out == pt_in && pt_oe == '1, "R10", "pads while on", pt_out, pt_in);
        end

        // R7: short press keeps the substate saved at press time.
        warn = 1'b1; serr = 1'b0; step(2);
        chk(led == 3'b110, "R5", "warning colour", led, 6);
        btn_n = 1'b0; step(DB + 4);
        warn = 1'b0; step(HOLD / 2);
        chk(led == 3'b110, "R7", "saved colour during hold", led, 6);
        chk(pwr_en == 1'b1, "R7", "power kept during hold", pwr_en, 1);
        btn_n = 1'b1; step(DB + 6);
        chk(led == 3'b010 && pwr_en, "R7", "back in operation", led, 2);

        // R6: long press powers off after hold and slot shutdown.
        btn_n = 1'b0;
        n = 0;
        while (led != 3'b001 && n < 1000) begin step(1); n++; end
        chk(n == DB + 3 + HOLD, "R6", "press to slot shutdown", n, DB + 3 + HOLD);
        hold_col = led;
        chk(pwr_en == 1'b1, "R6", "power on in slot shutdown", pwr_en, 1);
        m = 0;
        while (pwr_en && m < 1000) begin step(1); m++; end
        chk(m == SLOT, "R6", "slot shutdown length", m, SLOT);
        chk(led == 3'b000 && pt_oe == '0, "R6", "off waiting release", led, 0);
        step(20);
        chk(pwr_en == 1'b0, "R6", "stays off while held", pwr_en, 0);
        btn_n = 1'b1; step(DB + 8);
        chk(pwr_en == 1'b0 && led == 3'b000 && hold_col == 3'b001, "R6",
            "idle after release", led, 0);

        // R8: hard error during operation.
        power_up();
        herr = 1'b1; step(1);
        chk(pwr_en == 1'b0 && led == 3'b100 && pt_oe == '0, "R8",
            "hard error response", {pwr_en, led}, 4);
        herr = 1'b0; step(8);
        chk(pwr_en == 1'b0 && led == 3'b100, "R8", "hard error latched", led, 4);

        // R9: acknowledge, release, then power up again.
        btn_n = 1'b0; step(DB + 6);
        chk(led == 3'b000 && pwr_en == 1'b0, "R9", "acknowledged", led, 0);
        btn_n = 1'b1; step(DB + 8);
        chk(led == 3'b000 && pwr_en == 1'b0, "R9", "idle after ack", led, 0);
        power_up();
        chk(pwr_en == 1'b1, "R9", "power up after ack", pwr_en, 1);

        // R8: hard error from idle as well.
        pg = 1'b0;
        btn_n = 1'b0; step(DB + 4 + HOLD + SLOT + 5);
        btn_n = 1'b1; step(DB + 8);
        chk(pwr_en == 1'b0, "R6", "off before idle error", pwr_en, 0);
        herr = 1'b1; step(1); herr = 1'b0; step(1);
        chk(led == 3'b100 && pwr_en == 1'b0, "R8", "hard error from idle", led, 4);
        btn_n = 1'b0; step(DB + 6); btn_n = 1'b1; step(DB + 8);
        chk(led == 3'b000, "R9", "ack from idle error", led, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule